// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps wall-clock time and a calendar as packed BCD bytes: seconds, minutes, hours, day of week, date, month and a two-digit year. A fast input pulse (`osc_tick`) feeds a sub-second prescaler of `PRESCALE` steps. Each time the prescaler completes, the time advances by one second, and the carry ripples through minutes, hours, day of week, date, month and year. The hours byte runs in either a 24-hour format or a 12-hour format with a PM flag. Month lengths, including February in leap years, are applied automatically.

A host writes any register one byte at a time through a strobe interface and reads the live value of any register combinationally. The host can hold a frozen copy of the seven time bytes for the length of a multi-byte read. A one-cycle strobe marks every completed second for downstream alarm comparison. A stop bit halts timekeeping and is set at reset.

Register index: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00 (24-hour), day of week 01, date 01, month 01, year 00, control 80h, and `sec_pulse` is low.
- R2: While running, the seconds advance by one after every `PRESCALE` sampled `osc_tick` pulses. `sec_pulse` is high for exactly the one cycle in which the new value first reads back.
- R3: Seconds and minutes count 00-59 in BCD. 23:59:59 in 24-hour mode rolls to 00:00:00 and advances the day.
- R4: Hours bit 6 = 1 selects 12-hour mode, with bit 5 as PM and hours 01-12. 11:59:59 toggles PM and shows 12. 12:59:59 shows 01 with PM unchanged. The day advances only on the step from 11 PM to 12 AM.
- R5: Day of week increments at midnight and wraps from 7 to 1.
- R6: Date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. Month wraps from 12 to 01 and advances the year, and year wraps from 99 to 00.
- R7: February ends on 29 when the year value is divisible by 4, and on 28 otherwise.
- R8: A seconds write (index 0) clears the prescaler. If it lands on the cycle that would complete a second, that second is not counted.
- R9: Writes to other indices leave the prescaler running. On a completing cycle, the written register takes the written byte and the others advance.
- R10: Control bit 7 = 1 stops the prescaler and all counting. Register writes are still accepted.
- R11: Bits with no function read 0. Seconds and minutes keep bits 6:0, hours 6:0, day 2:0, date 5:0, month 4:0, year 7:0, and control only bit 7.
- R12: When `snap_hold` is first sampled high, the seven time bytes are copied into a snapshot. `snap_data` returns the snapshot byte at `rd_addr` (00h at index 7). The snapshot does not change while `snap_hold` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Prescaler step pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index to write |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | 3 | Register index to read |
| rd_data | output | 8 | Live register byte |
| snap_hold | input | 1 | Read transaction active; capture on first cycle |
| snap_data | output | 8 | Snapshot register byte |
| sec_pulse | output | 1 | One-cycle strobe per counted second |

## Verification
The assertions on the digit ranges and the day-of-week value assume the host writes only legal BCD values with legal field combinations. Behaviour after an illegal write is left undefined. The stimulus therefore writes only valid times and dates, and exercises the unused bits only around legal values. Tick pulses and writes change only on the falling clock edge. Tick pulses are at least one cycle apart, except where a write is placed on the completing tick on purpose.

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       snap_hold,
  output logic [7:0] snap_data,
  output logic       sec_pulse
);

  localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [6:0] r_sec, r_min, r_hour;
  logic [2:0] r_dow;
  logic [5:0] r_date;
  logic [4:0] r_mon;
  logic [7:0] r_year;
  logic       r_halt;
  logic [CW-1:0] pre_cnt;
  logic       snap_prev;
  logic [6:0][7:0] snap_q;
  logic [7:0][7:0] live;
  logic [7:0][7:0] snap_all;

  assign live[0] = {1'b0, r_sec};
  assign live[1] = {1'b0, r_min};
  assign live[2] = {1'b0, r_hour};
  assign live[3] = {5'b0, r_dow};
  assign live[4] = {2'b0, r_date};
  assign live[5] = {3'b0, r_mon};
  assign live[6] = r_year;
  assign live[7] = {r_halt, 7'b0};
  assign rd_data = live[rd_addr];

  assign snap_all  = {8'h00, snap_q};
  assign snap_data = snap_all[rd_addr];

  logic sec_wr, step;
  assign sec_wr = wr_en && (wr_addr == 3'd0);
  assign step   = osc_tick && !r_halt && !sec_wr && (pre_cnt == LAST);

  logic [6:0] sec_inc, min_inc;
  logic [5:0] date_inc, h24_inc;
  logic [4:0] mon_inc, h12_inc;
  logic [7:0] year_inc;
  logic [2:0] dow_nx;

  assign sec_inc  = (r_sec[3:0] == 4'd9) ? {r_sec[6:4] + 3'd1, 4'd0} : {r_sec[6:4], r_sec[3:0] + 4'd1};
  assign min_inc  = (r_min[3:0] == 4'd9) ? {r_min[6:4] + 3'd1, 4'd0} : {r_min[6:4], r_min[3:0] + 4'd1};
  assign h24_inc  = (r_hour[3:0] == 4'd9) ? {r_hour[5:4] + 2'd1, 4'd0} : {r_hour[5:4], r_hour[3:0] + 4'd1};
  assign h12_inc  = (r_hour[3:0] == 4'd9) ? 5'h10 : {r_hour[4], r_hour[3:0] + 4'd1};
  assign date_inc = (r_date[3:0] == 4'd9) ? {r_date[5:4] + 2'd1, 4'd0} : {r_date[5:4], r_date[3:0] + 4'd1};
  assign mon_inc  = (r_mon[3:0] == 4'd9) ? 5'h10 : {r_mon[4], r_mon[3:0] + 4'd1};
  assign year_inc = (r_year[3:0] == 4'd9) ? {r_year[7:4] + 4'd1, 4'd0} : {r_year[7:4], r_year[3:0] + 4'd1};
  assign dow_nx   = (r_dow == 3'd7) ? 3'd1 : r_dow + 3'd1;

  logic sec_end, min_end, mon_end, year_end, date_end;
  assign sec_end  = (r_sec == 7'h59);
  assign min_end  = (r_min == 7'h59);
  assign mon_end  = (r_mon == 5'h12);
  assign year_end = (r_year == 8'h99);

  logic [1:0] lsum;
  logic       leap;
  assign lsum = {r_year[4], 1'b0} + r_year[1:0];
  assign leap = (lsum == 2'd0);

  logic [5:0] last_day;
  always_comb begin
    case (r_mon)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end
  assign date_end = (r_date == last_day);

  logic [6:0] hour_nx;
  logic       day_carry;
  always_comb begin
    day_carry = 1'b0;
    if (r_hour[6]) begin
      if (r_hour[4:0] == 5'h12) begin
        hour_nx = {1'b1, r_hour[5], 5'h01};
      end else if (r_hour[4:0] == 5'h11) begin
        hour_nx   = {1'b1, ~r_hour[5], 5'h12};
        day_carry = r_hour[5];
      end else begin
        hour_nx = {1'b1, r_hour[5], h12_inc};
      end
    end else if (r_hour[5:0] == 6'h23) begin
      hour_nx   = 7'h00;
      day_carry = 1'b1;
    end else begin
      hour_nx = {1'b0, h24_inc};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_sec  <= 7'h00;
      r_min  <= 7'h00;
      r_hour <= 7'h00;
      r_dow  <= 3'd1;
      r_date <= 6'h01;
      r_mon  <= 5'h01;
      r_year <= 8'h00;
      r_halt <= 1'b1;
    end else begin
      if (step) begin
        r_sec <= sec_end ? 7'h00 : sec_inc;
        if (sec_end) begin
          r_min <= min_end ? 7'h00 : min_inc;
          if (min_end) begin
            r_hour <= hour_nx;
            if (day_carry) begin
              r_dow  <= dow_nx;
              r_date <= date_end ? 6'h01 : date_inc;
              if (date_end) begin
                r_mon <= mon_end ? 5'h01 : mon_inc;
                if (mon_end) r_year <= year_end ? 8'h00 : year_inc;
              end
            end
          end
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: r_sec  <= wr_data[6:0];
          3'd1: r_min  <= wr_data[6:0];
          3'd2: r_hour <= wr_data[6:0];
          3'd3: r_dow  <= wr_data[2:0];
          3'd4: r_date <= wr_data[5:0];
          3'd5: r_mon  <= wr_data[4:0];
          3'd6: r_year <= wr_data;
          default: r_halt <= wr_data[7];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= step;
      if (sec_wr) pre_cnt <= '0;
      else if (osc_tick && !r_halt) pre_cnt <= (pre_cnt == LAST) ? '0 : pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_prev <= 1'b0;
      snap_q    <= '0;
    end else begin
      snap_prev <= snap_hold;
      if (snap_hold && !snap_prev) snap_q <= live[6:0];
    end
  end

  // R8
  presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (pre_cnt == '0));

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_halt && !wr_en) |=> ($stable(r_sec) && $stable(r_min) && $stable(r_hour) && $stable(r_date) && !sec_pulse));

  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> ($past(osc_tick) && !$past(r_halt)));

  // R12
  snap_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_hold && snap_prev) |=> $stable(snap_q));

  // R5
  dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_dow != 3'd0);

  // R3
  sec_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_sec[3:0] <= 4'd9) && (r_min[3:0] <= 4'd9));

endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic snap_hold = 1'b0;
  logic [7:0] snap_data;
  logic sec_pulse;

  always #4 clk = ~clk;

  rtc_calendar_core #(.PRESCALE(P)) i_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .snap_hold(snap_hold), .snap_data(snap_data), .sec_pulse(sec_pulse)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_sec, m_min, m_hv, m_dow, m_date, m_mon, m_year, m_cnt;
  bit m_pm, m_h12, m_halt, m_pulse, m_prev;
  logic [7:0] m_snap [0:6];

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int unbcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] byte_of(input int a);
    case (a)
      0: return bcd(m_sec);
      1: return bcd(m_min);
      2: return m_h12 ? (8'h40 | (m_pm ? 8'h20 : 8'h00) | bcd(m_hv)) : bcd(m_hv);
      3: return 8'(m_dow);
      4: return bcd(m_date);
      5: return bcd(m_mon);
      6: return bcd(m_year);
      default: return m_halt ? 8'h80 : 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      7: return "R10";
      default: return "R6";
    endcase
  endfunction

  task automatic advance();
    bit day;
    day = 0;
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0;
      m_min++;
      if (m_min == 60) begin
        m_min = 0;
        if (m_h12) begin
          if (m_hv == 11) begin m_hv = 12; m_pm = !m_pm; day = !m_pm; end
          else if (m_hv == 12) m_hv = 1;
          else m_hv++;
        end else begin
          m_hv++;
          if (m_hv == 24) begin m_hv = 0; day = 1; end
        end
      end
    end
    if (day) begin
      m_dow = (m_dow == 7) ? 1 : m_dow + 1;
      m_date++;
      if (m_date > mdays(m_mon, m_year)) begin
        m_date = 1;
        m_mon++;
        if (m_mon > 12) begin m_mon = 1; m_year = (m_year + 1) % 100; end
      end
    end
  endtask

  task automatic apply_write(input int a, input logic [7:0] d);
    case (a)
      0: m_sec = unbcd(d & 8'h7F);
      1: m_min = unbcd(d & 8'h7F);
      2: begin
        m_h12 = d[6];
        if (d[6]) begin m_pm = d[5]; m_hv = unbcd(d & 8'h1F); end
        else begin m_pm = 0; m_hv = unbcd(d & 8'h3F); end
      end
      3: m_dow = int'(d[2:0]);
      4: m_date = unbcd(d & 8'h3F);
      5: m_mon = unbcd(d & 8'h1F);
      6: m_year = unbcd(d);
      default: m_halt = d[7];
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hv = 0; m_pm = 0; m_h12 = 0;
      m_dow = 1; m_date = 1; m_mon = 1; m_year = 0;
      m_halt = 1; m_cnt = 0; m_pulse = 0; m_prev = 0;
      for (int i = 0; i < 7; i++) m_snap[i] = 8'h00;
    end else begin
      bit st;
      st = 0;
      if (snap_hold && !m_prev)
        for (int i = 0; i < 7; i++) m_snap[i] = byte_of(i);
      m_prev = snap_hold;
      if (wr_en && wr_addr == 3'd0) m_cnt = 0;
      else if (osc_tick && !m_halt) begin
        if (m_cnt == P - 1) begin m_cnt = 0; st = 1; end
        else m_cnt++;
      end
      if (st) advance();
      if (wr_en) apply_write(int'(wr_addr), wr_data);
      m_pulse = st;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk(tag_of(int'(rd_addr)), rd_data, byte_of(int'(rd_addr)));
      chk("R12", snap_data, (rd_addr == 3'd7) ? 8'h00 : m_snap[rd_addr]);
      chk("R2", {7'b0, sec_pulse}, {7'b0, m_pulse});
    end
  end

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); osc_tick = 1'b1; rd_addr = rd_addr + 3'd1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_tick(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = d; osc_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; osc_tick = 1'b0;
  endtask

  task automatic expect_rd(input string tag, input int a, input logic [7:0] exp);
    @(negedge clk); rd_addr = 3'(a); #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic expect_snap(input string tag, input int a, input logic [7:0] exp);
    @(negedge clk); rd_addr = 3'(a); #1;
    chk(tag, snap_data, exp);
  endtask

  task automatic set_all(input logic [7:0] hr, input logic [7:0] dw, input logic [7:0] dt,
                         input logic [7:0] mo, input logic [7:0] yr);
    wr(1, 8'h59); wr(2, hr); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, yr); wr(0, 8'h59);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    expect_rd("R1", 0, 8'h00); expect_rd("R1", 1, 8'h00); expect_rd("R1", 2, 8'h00);
    expect_rd("R1", 3, 8'h01); expect_rd("R1", 4, 8'h01); expect_rd("R1", 5, 8'h01);
    expect_rd("R1", 6, 8'h00); expect_rd("R1", 7, 8'h80);
    chk("R1", {7'b0, sec_pulse}, 8'h00);
    // R10 halted at reset, writes still accepted
    tick(12);
    expect_rd("R10", 0, 8'h00);
    wr(1, 8'h15);
    expect_rd("R10", 1, 8'h15);
    // R11 control keeps only bit 7
    wr(7, 8'h7F);
    expect_rd("R11", 7, 8'h00);
    // R2 one second per P ticks
    tick(12);
    expect_rd("R2", 0, 8'h03);
    // R11 unused bits masked
    wr(0, 8'hC5); expect_rd("R11", 0, 8'h45);
    wr(3, 8'hFB); expect_rd("R11", 3, 8'h03);
    wr(4, 8'hD7); expect_rd("R11", 4, 8'h17);
    wr(5, 8'hE9); expect_rd("R11", 5, 8'h09);
    wr(2, 8'h93); expect_rd("R11", 2, 8'h13);
    // R3 R5 R6 full rollover
    set_all(8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick(4);
    expect_rd("R3", 0, 8'h00); expect_rd("R3", 1, 8'h00); expect_rd("R3", 2, 8'h00);
    expect_rd("R5", 3, 8'h01); expect_rd("R6", 4, 8'h01); expect_rd("R6", 5, 8'h01);
    expect_rd("R6", 6, 8'h00);
    // R6 30-day month
    set_all(8'h23, 8'h02, 8'h30, 8'h04, 8'h25);
    tick(4);
    expect_rd("R6", 4, 8'h01); expect_rd("R6", 5, 8'h05); expect_rd("R5", 3, 8'h03);
    // R6 31-day month does not wrap at 30
    set_all(8'h23, 8'h02, 8'h30, 8'h05, 8'h25);
    tick(4);
    expect_rd("R6", 4, 8'h31); expect_rd("R6", 5, 8'h05);
    // R7 leap and non-leap February
    set_all(8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    tick(4);
    expect_rd("R7", 4, 8'h29); expect_rd("R7", 5, 8'h02);
    set_all(8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
    tick(4);
    expect_rd("R7", 4, 8'h01); expect_rd("R7", 5, 8'h03);
    set_all(8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    tick(4);
    expect_rd("R7", 4, 8'h01); expect_rd("R7", 5, 8'h03);
    set_all(8'h23, 8'h02, 8'h28, 8'h02, 8'h10);
    tick(4);
    expect_rd("R7", 4, 8'h01);
    set_all(8'h23, 8'h02, 8'h28, 8'h02, 8'h12);
    tick(4);
    expect_rd("R7", 4, 8'h29);
    // R4 12-hour transitions
    set_all(8'h51, 8'h01, 8'h10, 8'h06, 8'h25);
    tick(4);
    expect_rd("R4", 2, 8'h72); expect_rd("R4", 4, 8'h10);
    set_all(8'h72, 8'h01, 8'h10, 8'h06, 8'h25);
    tick(4);
    expect_rd("R4", 2, 8'h61);
    set_all(8'h71, 8'h01, 8'h10, 8'h06, 8'h25);
    tick(4);
    expect_rd("R4", 2, 8'h52); expect_rd("R4", 4, 8'h11); expect_rd("R4", 3, 8'h02);
    // R8 seconds write clears the prescaler
    wr(0, 8'h10); tick(2); wr(0, 8'h20);
    tick(3); expect_rd("R8", 0, 8'h20);
    tick(1); expect_rd("R8", 0, 8'h21);
    tick(3); wr_tick(0, 8'h30);
    expect_rd("R8", 0, 8'h30);
    tick(3); expect_rd("R8", 0, 8'h30);
    tick(1); expect_rd("R8", 0, 8'h31);
    // R9 other writes leave the prescaler alone
    tick(2); wr(1, 8'h44); tick(2);
    expect_rd("R9", 0, 8'h32); expect_rd("R9", 1, 8'h44);
    tick(3); wr_tick(1, 8'h07);
    expect_rd("R9", 0, 8'h33); expect_rd("R9", 1, 8'h07);
    // R12 snapshot
    @(negedge clk); snap_hold = 1'b1;
    @(negedge clk);
    tick(8);
    expect_rd("R12", 0, 8'h35);
    expect_snap("R12", 0, 8'h33); expect_snap("R12", 1, 8'h07); expect_snap("R12", 7, 8'h00);
    @(negedge clk); snap_hold = 1'b0;
    @(negedge clk); snap_hold = 1'b1;
    @(negedge clk);
    expect_snap("R12", 0, 8'h35);
    @(negedge clk); snap_hold = 1'b0;
    // R10 halt stops counting
    wr(7, 8'h80);
    tick(8);
    expect_rd("R10", 0, 8'h35); expect_rd("R10", 7, 8'h80);
    // free run against the model
    wr(7, 8'h00);
    set_all(8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    tick(400);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule